// File: doc/BRIEF.md
# Serial Handshake and Bus Driver Enable

This block drives the handshake pins of a serial port. It checks the incoming clear-to-send line before the transmitter may start a frame. It generates the request-to-send output from the receive buffer state. In half-duplex bus mode it uses the same output pin to drive a line transceiver's driver enable instead.

The transmitter reports two things: whether a frame is being shifted out (`txActive`, high through the final stop bit) and whether more data waits to be sent (`txPending`). The receiver reports whether it can accept another character (`rxReady`). The clear-to-send pin passes through a synchronizer. Every change in its synchronized level sets a sticky change flag, which can raise an interrupt request. Software clears the flag by pulsing `ctsChgClr`.

Top module: `uflow_hs`

## Requirements
- R1: After reset, with every configuration input at 0, `rtsDePin` is 0, `txPermit` is 1, `ctsChgFlag` is 0 and `irq` is 0.
- R2: With `cfgBusMode`=1, `rtsDePin` carries the driver enable XOR `cfgDePol`. With `cfgDePol`=0 the enable is active high, and with 1 it is active low.
- R3: The driver enable is high in every cycle in which `txActive`=1. It stays high while `txActive` is 0 and `txPending` is 1, provided it was high in the previous cycle. It drops in the same cycle that both inputs are 0. `txPending` alone, starting from idle, does not raise it.
- R4: With `cfgBusMode`=0 and `cfgRtsEn`=1, `rtsDePin` equals NOT `rxReady`: it is low while the receiver can accept data and high once the buffer is full.
- R5: With `cfgBusMode`=0 and `cfgRtsEn`=0, `rtsDePin` is held low whatever `rxReady` does.
- R6: With `cfgCtsEn`=0, `txPermit` is 1 whatever level the clear-to-send pin has.
- R7: With `cfgCtsEn`=1 and `txActive`=0, `txPermit` is 1 only while the synchronized clear-to-send level is low (asserted). A pin change reaches `txPermit` after two rising clock edges.
- R8: While `txActive`=1, `txPermit` is 1 whatever the clear-to-send level, so a frame already started always completes.
- R9: Each change of the synchronized clear-to-send level sets `ctsChgFlag`, three rising edges after the pin changes. The flag stays set until it is cleared.
- R10: `ctsChgClr`=1 clears `ctsChgFlag` at the next edge. If a new change arrives in that same cycle, the set wins.
- R11: `irq` is 1 exactly when `ctsChgFlag`=1 and `cfgCtsIrqEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBusMode | input | 1 | 1: pin carries driver enable; 0: pin carries request-to-send |
| cfgDePol | input | 1 | Driver enable polarity, 0 active high, 1 active low |
| cfgCtsEn | input | 1 | Enable clear-to-send gating of frame starts |
| cfgRtsEn | input | 1 | Enable request-to-send generation |
| cfgCtsIrqEn | input | 1 | Enable interrupt on clear-to-send change |
| txActive | input | 1 | Transmitter shifting a frame, through the stop bit |
| txPending | input | 1 | Further transmit data is queued |
| rxReady | input | 1 | Receiver can accept another character |
| ctsPinN | input | 1 | Raw clear-to-send pin, active low |
| ctsChgClr | input | 1 | Write-one pulse clearing the change flag |
| rtsDePin | output | 1 | Shared request-to-send / driver-enable pin |
| txPermit | output | 1 | Transmitter may start a frame |
| ctsChgFlag | output | 1 | Sticky clear-to-send change flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default two-stage synchronizer. This makes the pin-to-permit delay of two edges and the pin-to-flag delay of three edges fixed numbers that the bench can check to the cycle. The block has only a few one-bit inputs, so the bench sweeps every combination of mode, polarity, request-to-send enable, transmit activity and receiver readiness against the pin. It also sweeps every combination of gating enable, clear-to-send level and transmit activity against the permit. Timed sequences then cover driver-enable hold across a gap between frames, and a set and a clear arriving in the same cycle.

// File: rtl/uflow_pkg.sv
package uflow_pkg;
  typedef struct packed {
    logic deOn;
    logic setChg;
    logic clrChg;
  } hsStrobe_t;
endpackage

// File: rtl/uflow_ctl.sv
module uflow_ctl
  import uflow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txActive,
  input  logic       txPending,
  input  logic       cfgCtsEn,
  input  logic       ctsLevel,
  input  logic       ctsEdge,
  input  logic       ctsChgClr,
  output hsStrobe_t  strb,
  output logic       txPermit
);
  logic deHeld;
  logic deNow;

  // enable spans back-to-back frames while data stays queued
  assign deNow = txActive | (deHeld & txPending);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deHeld <= 1'b0;
    else       deHeld <= deNow;
  end

  always_comb begin
    strb.deOn   = deNow;
    strb.setChg = ctsEdge;
    strb.clrChg = ctsChgClr;
  end

  // a running frame is never stopped; gating applies to starts only
  assign txPermit = txActive | ~cfgCtsEn | ~ctsLevel;
endmodule

// File: rtl/uflow_dp.sv
module uflow_dp
  import uflow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsPinN,
  input  logic       cfgBusMode,
  input  logic       cfgDePol,
  input  logic       cfgRtsEn,
  input  logic       cfgCtsIrqEn,
  input  logic       rxReady,
  input  hsStrobe_t  strb,
  output logic       ctsLevel,
  output logic       ctsEdge,
  output logic       rtsDePin,
  output logic       ctsChgFlag,
  output logic       irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          ctsPrev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= 1'b1;
        else if (s == 0) syncQ[s] <= ctsPinN;
        else             syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign ctsLevel = syncQ[LAST];
  assign ctsEdge  = ctsLevel ^ ctsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsPrev    <= 1'b1;
      ctsChgFlag <= 1'b0;
    end else begin
      ctsPrev <= ctsLevel;
      if (strb.setChg)      ctsChgFlag <= 1'b1;
      else if (strb.clrChg) ctsChgFlag <= 1'b0;
    end
  end

  always_comb begin
    if (cfgBusMode)    rtsDePin = strb.deOn ^ cfgDePol;
    else if (cfgRtsEn) rtsDePin = ~rxReady;
    else               rtsDePin = 1'b0;
  end

  assign irq = ctsChgFlag & cfgCtsIrqEn;
endmodule

// File: rtl/uflow_hs.sv
module uflow_hs
  import uflow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgBusMode,
  input  logic cfgDePol,
  input  logic cfgCtsEn,
  input  logic cfgRtsEn,
  input  logic cfgCtsIrqEn,
  input  logic txActive,
  input  logic txPending,
  input  logic rxReady,
  input  logic ctsPinN,
  input  logic ctsChgClr,
  output logic rtsDePin,
  output logic txPermit,
  output logic ctsChgFlag,
  output logic irq
);
  hsStrobe_t strb;
  logic      ctsLevel;
  logic      ctsEdge;

  uflow_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .txActive  (txActive),
    .txPending (txPending),
    .cfgCtsEn  (cfgCtsEn),
    .ctsLevel  (ctsLevel),
    .ctsEdge   (ctsEdge),
    .ctsChgClr (ctsChgClr),
    .strb      (strb),
    .txPermit  (txPermit)
  );

  uflow_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctsPinN     (ctsPinN),
    .cfgBusMode  (cfgBusMode),
    .cfgDePol    (cfgDePol),
    .cfgRtsEn    (cfgRtsEn),
    .cfgCtsIrqEn (cfgCtsIrqEn),
    .rxReady     (rxReady),
    .strb        (strb),
    .ctsLevel    (ctsLevel),
    .ctsEdge     (ctsEdge),
    .rtsDePin    (rtsDePin),
    .ctsChgFlag  (ctsChgFlag),
    .irq         (irq)
  );
endmodule

// File: rtl/uflow_hs_chk.sv
module uflow_hs_chk (
  input logic clk,
  input logic rstN,
  input logic cfgBusMode,
  input logic cfgDePol,
  input logic cfgCtsEn,
  input logic cfgRtsEn,
  input logic cfgCtsIrqEn,
  input logic txActive,
  input logic txPending,
  input logic rxReady,
  input logic ctsChgClr,
  input logic rtsDePin,
  input logic txPermit,
  input logic ctsChgFlag,
  input logic irq
);
  p_de_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBusMode && txActive) |-> (rtsDePin == !cfgDePol));

  p_de_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBusMode && !txActive && !txPending) |-> (rtsDePin == cfgDePol));

  p_rts_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgBusMode && cfgRtsEn) |-> (rtsDePin == !rxReady));

  p_rts_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgBusMode && !cfgRtsEn) |-> !rtsDePin);

  p_no_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCtsEn |-> txPermit);

  p_frame_runs_r8: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> txPermit);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctsChgFlag && !ctsChgClr) |=> ctsChgFlag);

  p_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq == (ctsChgFlag && cfgCtsIrqEn));
endmodule

bind uflow_hs uflow_hs_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgBusMode  (cfgBusMode),
  .cfgDePol    (cfgDePol),
  .cfgCtsEn    (cfgCtsEn),
  .cfgRtsEn    (cfgRtsEn),
  .cfgCtsIrqEn (cfgCtsIrqEn),
  .txActive    (txActive),
  .txPending   (txPending),
  .rxReady     (rxReady),
  .ctsChgClr   (ctsChgClr),
  .rtsDePin    (rtsDePin),
  .txPermit    (txPermit),
  .ctsChgFlag  (ctsChgFlag),
  .irq         (irq)
);

// File: tb/uflow_hs_tb.sv
`timescale 1ns/1ps
module uflow_hs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgBusMode = 0, cfgDePol = 0, cfgCtsEn = 0, cfgRtsEn = 0, cfgCtsIrqEn = 0;
  logic txActive = 0, txPending = 0, rxReady = 1, ctsPinN = 1, ctsChgClr = 0;
  logic rtsDePin, txPermit, ctsChgFlag, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uflow_hs u_dut (
    .clk(clk), .rstN(rstN), .cfgBusMode(cfgBusMode), .cfgDePol(cfgDePol),
    .cfgCtsEn(cfgCtsEn), .cfgRtsEn(cfgRtsEn), .cfgCtsIrqEn(cfgCtsIrqEn),
    .txActive(txActive), .txPending(txPending), .rxReady(rxReady),
    .ctsPinN(ctsPinN), .ctsChgClr(ctsChgClr), .rtsDePin(rtsDePin),
    .txPermit(txPermit), .ctsChgFlag(ctsChgFlag), .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(rtsDePin, 1'b0, "R1 pin");
    chk(txPermit, 1'b1, "R1 permit");
    chk(ctsChgFlag, 1'b0, "R1 flag");
    chk(irq, 1'b0, "R1 irq");

    // R2 R4 R5: full sweep of pin mux with nothing queued
    for (int v = 0; v < 32; v++) begin
      cfgBusMode = v[0]; cfgDePol = v[1]; cfgRtsEn = v[2];
      txActive = v[3]; rxReady = v[4]; txPending = 0;
      tick();
      if (v[0])      chk(rtsDePin, v[3] ^ v[1], "R2 bus pin");
      else if (v[2]) chk(rtsDePin, ~v[4], "R4 rts pin");
      else           chk(rtsDePin, 1'b0, "R5 rts off");
    end

    // R3 hold across gap, release, no start from pending alone
    for (int p = 0; p < 2; p++) begin
      cfgBusMode = 1; cfgDePol = p[0]; txActive = 0; txPending = 0;
      tick();
      txPending = 1; #1;
      chk(rtsDePin, p[0], "R3 pending alone");
      txActive = 1; tick();
      chk(rtsDePin, ~p[0], "R3 frame");
      txActive = 0; #1;
      chk(rtsDePin, ~p[0], "R3 gap same cycle");
      tick();
      chk(rtsDePin, ~p[0], "R3 gap held");
      txActive = 1; tick();
      txActive = 0; txPending = 0; #1;
      chk(rtsDePin, p[0], "R3 release");
      tick();
    end
    cfgBusMode = 0; cfgDePol = 0;

    // R6 R7 R8 permit sweep
    for (int v = 0; v < 8; v++) begin
      cfgCtsEn = v[0]; ctsPinN = v[1]; txActive = v[2];
      tick(); tick(); tick();
      if (v[2])      chk(txPermit, 1'b1, "R8 active");
      else if (!v[0]) chk(txPermit, 1'b1, "R6 ungated");
      else           chk(txPermit, ~v[1], "R7 gated");
    end
    txActive = 0; cfgCtsEn = 1;

    // R7 latency, R9 flag timing
    ctsChgClr = 1; tick(); ctsChgClr = 0;
    chk(ctsChgFlag, 1'b0, "R10 clear");
    ctsPinN = 0;  // pin currently 1 from sweep
    tick();
    chk(txPermit, 1'b0, "R7 one edge");
    tick();
    chk(txPermit, 1'b1, "R7 two edges");
    chk(ctsChgFlag, 1'b0, "R9 two edges");
    tick();
    chk(ctsChgFlag, 1'b1, "R9 three edges");
    cfgCtsIrqEn = 0; #1;
    chk(irq, 1'b0, "R11 masked");
    cfgCtsIrqEn = 1; #1;
    chk(irq, 1'b1, "R11 raised");
    repeat (5) tick();
    chk(ctsChgFlag, 1'b1, "R9 sticky");

    // R10 clear, then set and clear together
    ctsChgClr = 1; tick(); ctsChgClr = 0;
    chk(ctsChgFlag, 1'b0, "R10 cleared");
    chk(irq, 1'b0, "R11 low");
    ctsPinN = 1;
    tick(); tick();
    ctsChgClr = 1; tick(); ctsChgClr = 0;
    chk(ctsChgFlag, 1'b1, "R10 set wins");

    finish();
  end
endmodule